// File: doc/BRIEF.md
# Programmable Feed-Forward Layer Engine

This block evaluates fully connected neural-network layers. It runs a short program held in an external code memory. It has a fixed array of multiply-accumulate cells, and the number of cells is a parameter. One instruction sends a single input sample to every cell, and each cell receives its own weight from one wide weight word. Each cell multiplies its sample by its weight and adds the product to its running sum. A second instruction picks one cell and passes that cell's sum through a single shared activation table. The result goes to the data memory. A third instruction clears every sum.

The data memory holds both the input samples and the results, so one layer's outputs can be read back as the next layer's inputs. A layer wider than the cell array can be computed in several passes that reuse the cells. This trades clock cycles for multipliers, and only the program changes. A host loads the memories, pulses `start` and waits for `done`.

Top module: `ffnet_layer_engine`

## Requirements
- R1: An instruction is 14 bits wide. Bits [13:12] hold the opcode: 00 = load, 01 = store, 10 = clear, 11 = halt. Bits [11:6] hold field A and bits [5:0] hold field B. Execution starts at code address 0 and advances by one per instruction.
- R2: Load reads the data word at address A and the weight word at address B. Lane i of the weight word (bits i*16 +: 16) goes to cell i. Each cell adds the full-precision product of the sample and its weight (signed Q8.8 × Q8.8, kept with 16 fraction bits in a 32-bit sum) to its running sum.
- R3: Store passes the sum of cell A through the activation and writes the result to data address B. The sum of cell A is left unchanged.
- R4: Clear sets the sums of all cells to zero. Reset does the same.
- R5: The table index for a sum s is 0 when s < -2^19 and 31 when s >= 2^19. Otherwise it is (s + 2^19) >> 15.
- R6: Table entry k (0..31) holds floor(256·(96·k² − 2·k³)/32768). Entries 0, 16 and 31 hold 0, 128 and 255.
- R7: A store whose cell index A is not below the cell count uses a sum of zero and so writes 128.
- R8: Each instruction takes a fixed number of clocks, including its fetch: load 4, store 5, clear 2. From the `start` edge to `done` the program takes 4·loads + 5·stores + 2·clears + 2 cycles.
- R9: Halt raises `done`. While `done` is high and `start` is low, the engine fetches nothing and accesses no memory. A `start` pulse in that state reruns the program from address 0.
- R10: All memories return read data one cycle after the read enable. The data port never reads and writes in the same cycle. A load can read a value that an earlier store wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts the program from address 0 when idle or done |
| done | output | 1 | High after a halt instruction |
| code_ren | output | 1 | Code memory read enable |
| code_addr | output | 6 | Code memory address |
| code_rdata | input | 14 | Instruction word, one cycle after enable |
| wt_ren | output | 1 | Weight memory read enable |
| wt_addr | output | 6 | Weight memory address |
| wt_rdata | input | 64 | One 16-bit weight per cell |
| dm_ren | output | 1 | Data memory read enable |
| dm_wen | output | 1 | Data memory write enable |
| dm_addr | output | 6 | Data memory address for read or write |
| dm_wdata | output | 16 | Activation result to write |
| dm_rdata | input | 16 | Input sample, one cycle after enable |

## Verification
The assertions assume that every memory returns its data exactly one cycle after its enable. They also assume that `start` is pulsed only while the engine is idle or done, and that every program ends in a halt. The bench models all three memories with that one-cycle latency. It pulses `start` only after `done` has been seen, and it fills every unused code word with halt. Random programs keep samples and weights within ±2.0, so sums stay far from 32-bit wrap. The saturation edges of the table are reached only through directed weights.

// File: rtl/fle_pkg.sv
package fle_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_CLEAR = 2'b10,
        OP_HALT  = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_LATCH,
        ST_ACC,
        ST_SEL,
        ST_LUT,
        ST_WRITE,
        ST_DONE
    } state_e;

    // datapath strobes issued by the sequencer
    typedef struct packed {
        logic clr;
        logic ld;
        logic acc;
        logic sel;
        logic lut;
        logic wr;
    } ctl_t;

    // smoothstep-shaped activation entry k of a table with 'depth' entries,
    // scaled so that the top of the curve equals 'one'
    function automatic int act_entry(input int k, input int depth, input int one);
        longint kk;
        longint dd;
        longint num;
        kk  = longint'(k);
        dd  = longint'(depth);
        num = longint'(one) * (3 * kk * kk * dd - 2 * kk * kk * kk);
        return int'(num / (dd * dd * dd));
    endfunction

endpackage

// File: rtl/fle_mac_cell.sv
module fle_mac_cell #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     ld,
    input  logic                     acc_en,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] w_in,
    output logic signed [ACC_W-1:0]  sum
);

    logic signed [DATA_W-1:0]   x_q;
    logic signed [DATA_W-1:0]   w_q;
    logic signed [2*DATA_W-1:0] prod;
    logic signed [ACC_W-1:0]    acc_q;

    assign prod = x_q * w_q;
    assign sum  = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            w_q   <= '0;
            acc_q <= '0;
        end else begin
            if (ld) begin
                x_q <= x_in;
                w_q <= w_in;
            end
            if (clr)
                acc_q <= '0;
            else if (acc_en)
                acc_q <= acc_q + ACC_W'(prod);
        end
    end

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0));

    a_r3_sum_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !acc_en) |=> $stable(acc_q));

endmodule

// File: rtl/fle_activation.sv
module fle_activation
    import fle_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ACC_W   = 32,
    parameter int FRAC_W  = 8,
    parameter int LUT_AW  = 5,
    parameter int WIN_EXP = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel_en,
    input  logic                    lut_en,
    input  logic signed [ACC_W-1:0] sum_in,
    output logic [DATA_W-1:0]       act_out
);

    localparam int DEPTH  = 1 << LUT_AW;
    localparam int ONE    = 1 << FRAC_W;
    localparam int EDGE_SH = WIN_EXP + 2 * FRAC_W;
    localparam int IDX_SH = EDGE_SH + 1 - LUT_AW;
    localparam longint HI_L = longint'(1) << EDGE_SH;
    localparam logic signed [ACC_W-1:0] HI = ACC_W'(HI_L);
    localparam logic signed [ACC_W-1:0] LO = ACC_W'(-HI_L);

    logic [DATA_W-1:0] table_w [DEPTH];
    logic [LUT_AW-1:0] idx_d;
    logic [LUT_AW-1:0] idx_q;
    logic [DATA_W-1:0] act_q;

    for (genvar k = 0; k < DEPTH; k++) begin : g_tab
        assign table_w[k] = DATA_W'(act_entry(k, DEPTH, ONE));
    end

    always_comb begin
        if (sum_in < LO)
            idx_d = '0;
        else if (sum_in >= HI)
            idx_d = '1;
        else
            idx_d = LUT_AW'((sum_in + HI) >>> IDX_SH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            act_q <= '0;
        end else begin
            if (sel_en)
                idx_q <= idx_d;
            if (lut_en)
                act_q <= table_w[idx_q];
        end
    end

    assign act_out = act_q;

    a_r5_low_clamp: assert property (@(posedge clk) disable iff (rst)
        (sel_en && sum_in < LO) |=> (idx_q == '0));

    a_r5_high_clamp: assert property (@(posedge clk) disable iff (rst)
        (sel_en && sum_in >= HI) |=> (idx_q == '1));

    a_r6_ceiling: assert property (@(posedge clk) disable iff (rst)
        lut_en |=> (act_q <= DATA_W'(ONE)));

endmodule

// File: rtl/fle_sequencer.sv
module fle_sequencer
    import fle_pkg::*;
#(
    parameter int PC_W  = 6,
    parameter int FLD_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [2*FLD_W+1:0]   code_rdata,
    output logic [PC_W-1:0]      code_addr,
    output logic                 code_ren,
    output logic                 wt_ren,
    output logic [FLD_W-1:0]     wt_addr,
    output logic                 dm_ren,
    output logic                 dm_wen,
    output logic [FLD_W-1:0]     dm_addr,
    output logic [FLD_W-1:0]     sel_idx,
    output ctl_t                 ctl,
    output logic                 done
);

    localparam int INSTR_W = 2 + 2 * FLD_W;

    state_e           st_q, st_d;
    logic [PC_W-1:0]  pc_q;
    logic [FLD_W-1:0] fa_q, fb_q;
    logic             pc_inc;
    logic             go;
    op_e              op_w;
    logic [FLD_W-1:0] fa_w, fb_w;

    assign op_w = op_e'(code_rdata[INSTR_W-1 -: 2]);
    assign fa_w = code_rdata[2*FLD_W-1 -: FLD_W];
    assign fb_w = code_rdata[FLD_W-1:0];
    assign go   = start && (st_q == ST_IDLE || st_q == ST_DONE);

    always_comb begin
        st_d     = st_q;
        pc_inc   = 1'b0;
        code_ren = 1'b0;
        wt_ren   = 1'b0;
        dm_ren   = 1'b0;
        dm_wen   = 1'b0;
        wt_addr  = '0;
        dm_addr  = '0;
        ctl      = '0;
        case (st_q)
            ST_IDLE, ST_DONE: if (start) st_d = ST_FETCH;
            ST_FETCH: begin
                code_ren = 1'b1;
                st_d     = ST_DECODE;
            end
            ST_DECODE: begin
                case (op_w)
                    OP_LOAD: begin
                        dm_ren  = 1'b1;
                        wt_ren  = 1'b1;
                        dm_addr = fa_w;
                        wt_addr = fb_w;
                        st_d    = ST_LATCH;
                    end
                    OP_STORE: st_d = ST_SEL;
                    OP_CLEAR: begin
                        ctl.clr = 1'b1;
                        pc_inc  = 1'b1;
                        st_d    = ST_FETCH;
                    end
                    default: st_d = ST_DONE;
                endcase
            end
            ST_LATCH: begin
                ctl.ld = 1'b1;
                st_d   = ST_ACC;
            end
            ST_ACC: begin
                ctl.acc = 1'b1;
                pc_inc  = 1'b1;
                st_d    = ST_FETCH;
            end
            ST_SEL: begin
                ctl.sel = 1'b1;
                st_d    = ST_LUT;
            end
            ST_LUT: begin
                ctl.lut = 1'b1;
                st_d    = ST_WRITE;
            end
            ST_WRITE: begin
                ctl.wr  = 1'b1;
                dm_wen  = 1'b1;
                dm_addr = fb_q;
                pc_inc  = 1'b1;
                st_d    = ST_FETCH;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            pc_q <= '0;
            fa_q <= '0;
            fb_q <= '0;
        end else begin
            st_q <= st_d;
            if (go)
                pc_q <= '0;
            else if (pc_inc)
                pc_q <= pc_q + 1'b1;
            if (st_q == ST_DECODE) begin
                fa_q <= fa_w;
                fb_q <= fb_w;
            end
        end
    end

    assign code_addr = pc_q;
    assign sel_idx   = fa_q;
    assign done      = (st_q == ST_DONE);

    a_r10_port_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dm_ren, dm_wen}));

    a_r8_fetch_gap: assert property (@(posedge clk) disable iff (rst)
        code_ren |=> !code_ren && !dm_wen);

    a_r8_write_then_fetch: assert property (@(posedge clk) disable iff (rst)
        dm_wen |=> code_ren);

    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && !code_ren && !dm_ren && !dm_wen));

endmodule

// File: rtl/ffnet_layer_engine.sv
module ffnet_layer_engine
    import fle_pkg::*;
#(
    parameter int NEURONS = 4,
    parameter int DATA_W  = 16,
    parameter int FRAC_W  = 8,
    parameter int ACC_W   = 32,
    parameter int FLD_W   = 6,
    parameter int PC_W    = 6,
    parameter int LUT_AW  = 5,
    parameter int WIN_EXP = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    output logic                        done,
    output logic                        code_ren,
    output logic [PC_W-1:0]             code_addr,
    input  logic [2*FLD_W+1:0]          code_rdata,
    output logic                        wt_ren,
    output logic [FLD_W-1:0]            wt_addr,
    input  logic [NEURONS*DATA_W-1:0]   wt_rdata,
    output logic                        dm_ren,
    output logic                        dm_wen,
    output logic [FLD_W-1:0]            dm_addr,
    output logic [DATA_W-1:0]           dm_wdata,
    input  logic [DATA_W-1:0]           dm_rdata
);

    ctl_t                    ctl;
    logic [FLD_W-1:0]        sel_idx;
    logic signed [ACC_W-1:0] sums [NEURONS];
    logic signed [ACC_W-1:0] sel_sum;

    fle_sequencer #(
        .PC_W  (PC_W),
        .FLD_W (FLD_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .code_rdata (code_rdata),
        .code_addr  (code_addr),
        .code_ren   (code_ren),
        .wt_ren     (wt_ren),
        .wt_addr    (wt_addr),
        .dm_ren     (dm_ren),
        .dm_wen     (dm_wen),
        .dm_addr    (dm_addr),
        .sel_idx    (sel_idx),
        .ctl        (ctl),
        .done       (done)
    );

    for (genvar i = 0; i < NEURONS; i++) begin : g_cell
        fle_mac_cell #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .clr    (ctl.clr),
            .ld     (ctl.ld),
            .acc_en (ctl.acc),
            .x_in   ($signed(dm_rdata)),
            .w_in   ($signed(wt_rdata[i*DATA_W +: DATA_W])),
            .sum    (sums[i])
        );
    end

    // cell indices past the array read as an empty sum
    always_comb begin
        sel_sum = '0;
        for (int i = 0; i < NEURONS; i++)
            if (sel_idx == FLD_W'(i))
                sel_sum = sums[i];
    end

    fle_activation #(
        .DATA_W  (DATA_W),
        .ACC_W   (ACC_W),
        .FRAC_W  (FRAC_W),
        .LUT_AW  (LUT_AW),
        .WIN_EXP (WIN_EXP)
    ) u_act (
        .clk     (clk),
        .rst     (rst),
        .sel_en  (ctl.sel),
        .lut_en  (ctl.lut),
        .sum_in  (sel_sum),
        .act_out (dm_wdata)
    );

endmodule

// File: tb/ffnet_layer_engine_tb.sv
module ffnet_layer_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int DW = 16;
    localparam int MD = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic done, code_ren, wt_ren, dm_ren, dm_wen;
    logic [5:0] code_addr, wt_addr, dm_addr;
    logic [13:0] code_q = '0;
    logic [N*DW-1:0] wt_q = '0;
    logic [DW-1:0] dm_q = '0;
    logic [DW-1:0] dm_wdata;

    logic [13:0]     code_mem [MD];
    logic [N*DW-1:0] wt_mem   [MD];
    logic [DW-1:0]   dm_mem   [MD];
    logic [DW-1:0]   ref_dm   [MD];

    int n_chk = 0;
    int n_fail = 0;
    int pp = 0;
    logic [DW-1:0] snap [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    ffnet_layer_engine u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .done       (done),
        .code_ren   (code_ren),
        .code_addr  (code_addr),
        .code_rdata (code_q),
        .wt_ren     (wt_ren),
        .wt_addr    (wt_addr),
        .wt_rdata   (wt_q),
        .dm_ren     (dm_ren),
        .dm_wen     (dm_wen),
        .dm_addr    (dm_addr),
        .dm_wdata   (dm_wdata),
        .dm_rdata   (dm_q)
    );

    // memories with one cycle of read latency (R10)
    always @(posedge clk) begin
        if (code_ren) code_q <= code_mem[code_addr];
        if (wt_ren)   wt_q   <= wt_mem[wt_addr];
        if (dm_ren)   dm_q   <= dm_mem[dm_addr];
        if (dm_wen)   dm_mem[dm_addr] <= dm_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // activation reference from R5 and R6
    function automatic logic [DW-1:0] ref_act(input longint s);
        longint k;
        if (s < -(longint'(1) << 19)) k = 0;
        else if (s >= (longint'(1) << 19)) k = 31;
        else k = (s + (longint'(1) << 19)) >>> 15;
        return DW'((256 * (96 * k * k - 2 * k * k * k)) / 32768);
    endfunction

    task automatic wipe();
        for (int a = 0; a < MD; a++) begin
            dm_mem[a] <= '0;
            ref_dm[a] = '0;
            code_mem[a] = 14'h3000;
            wt_mem[a] = '0;
        end
        pp = 0;
    endtask

    task automatic put(input logic [1:0] op, input int a, input int b);
        code_mem[pp] = {op, 6'(a), 6'(b)};
        pp++;
    endtask

    task automatic setd(input int a, input int v);
        dm_mem[a] <= DW'(v);
        ref_dm[a] = DW'(v);
    endtask

    task automatic setw(input int a, input int l0, input int l1, input int l2, input int l3);
        wt_mem[a] = {DW'(l3), DW'(l2), DW'(l1), DW'(l0)};
    endtask

    // program interpreter from R1..R4, R7, R8
    task automatic ref_run(output int cyc);
        longint acc [N];
        int pc;
        bit fin;
        logic [13:0] ins;
        int a, b;
        longint x, w;
        pc = 0; fin = 0; cyc = 0;
        for (int i = 0; i < N; i++) acc[i] = 0;
        while (!fin && pc < MD) begin
            ins = code_mem[pc];
            a = int'(ins[11:6]);
            b = int'(ins[5:0]);
            case (ins[13:12])
                2'b00: begin
                    x = longint'($signed(ref_dm[a]));
                    for (int i = 0; i < N; i++) begin
                        w = longint'($signed(wt_mem[b][i*DW +: DW]));
                        acc[i] += x * w;
                    end
                    cyc += 4;
                end
                2'b01: begin
                    ref_dm[b] = ref_act(a < N ? acc[a] : 0);
                    cyc += 5;
                end
                2'b10: begin
                    for (int i = 0; i < N; i++) acc[i] = 0;
                    cyc += 2;
                end
                default: begin
                    fin = 1;
                    cyc += 2;
                end
            endcase
            pc++;
        end
    endtask

    task automatic run_prog(output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic exec_check(input string req);
        int cyc, exp_cyc, bad;
        ref_run(exp_cyc);
        run_prog(cyc);
        chk(cyc == exp_cyc, "R8", "start-to-done cycles", cyc, exp_cyc);
        bad = -1;
        for (int a = 0; a < MD; a++)
            if (bad < 0 && dm_mem[a] !== ref_dm[a]) bad = a;
        chk(bad < 0, req, "data memory image",
            bad < 0 ? 0 : longint'(dm_mem[bad]), bad < 0 ? 0 : longint'(ref_dm[bad]));
    endtask

    task automatic rnd_word(output int v);
        v = int'($urandom_range(1023)) - 512;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v, k_in, h_n, l0, l1, l2, l3;
        void'($urandom(32'h1f3a5));
        wipe();
        repeat (3) @(negedge clk);
        // reset state (R4, R9)
        chk(done == 1'b0 && code_ren == 1'b0, "R9", "idle after reset",
            {done, code_ren}, 0);
        chk(dm_wen == 1'b0 && dm_ren == 1'b0, "R10", "no access in reset", {dm_wen, dm_ren}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && code_ren == 1'b0, "R9", "idle without start", {done, code_ren}, 0);

        // directed 2-4-1 network over the full cell array (R1 R2 R3 R10)
        wipe();
        setd(0, 200); setd(1, -150);
        setw(0, 256, -300, 120, 500);
        setw(1, 90, 400, -256, -60);
        setw(2, 300, 1, 2, 3);
        setw(3, -200, 4, 5, 6);
        setw(4, 150, 7, 8, 9);
        setw(5, -100, 10, 11, 12);
        put(2'b10, 0, 0);
        put(2'b00, 0, 0); put(2'b00, 1, 1);
        for (int n = 0; n < 4; n++) put(2'b01, n, 10 + n);
        put(2'b10, 0, 0);
        for (int n = 0; n < 4; n++) put(2'b00, 10 + n, 2 + n);
        put(2'b01, 0, 20);
        put(2'b11, 0, 0);
        @(negedge clk);
        exec_check("R1 R2 R3 R10");
        for (int n = 0; n < 4; n++) snap[n] = dm_mem[10 + n];
        snap[4] = dm_mem[20];

        // same network computed by cell 0 alone, one hidden unit per pass (R2 R4)
        pp = 0;
        for (int n = 0; n < 4; n++) begin
            put(2'b10, 0, 0);
            put(2'b00, 0, 40 + 2 * n); put(2'b00, 1, 41 + 2 * n);
            put(2'b01, 0, 10 + n);
        end
        put(2'b10, 0, 0);
        for (int n = 0; n < 4; n++) put(2'b00, 10 + n, 2 + n);
        put(2'b01, 0, 20);
        put(2'b11, 0, 0);
        for (int n = 0; n < 4; n++) begin
            l0 = int'($signed(wt_mem[0][n*DW +: DW]));
            l1 = int'($signed(wt_mem[1][n*DW +: DW]));
            setw(40 + 2 * n, l0, 0, 0, 0);
            setw(41 + 2 * n, l1, 0, 0, 0);
        end
        for (int n = 0; n < 4; n++) begin
            dm_mem[10 + n] <= '0;
            ref_dm[10 + n] = '0;
        end
        dm_mem[20] <= '0;
        ref_dm[20] = '0;
        @(negedge clk);
        exec_check("R2 R4");
        v = 0;
        for (int n = 0; n < 4; n++) if (dm_mem[10 + n] !== snap[n]) v++;
        if (dm_mem[20] !== snap[4]) v++;
        chk(v == 0, "R2", "single-cell result equals array result", v, 0);

        // table edges, out-of-range cell, clear, sum kept by store
        wipe();
        setd(0, 256);
        setw(0, 2047, 2048, -2048, -2049);
        put(2'b10, 0, 0);
        put(2'b00, 0, 0);
        put(2'b01, 0, 30); put(2'b01, 1, 31); put(2'b01, 2, 32); put(2'b01, 3, 33);
        put(2'b01, 7, 34);
        put(2'b01, 0, 36);
        put(2'b10, 0, 0);
        put(2'b01, 0, 35);
        put(2'b11, 0, 0);
        @(negedge clk);
        exec_check("R5 R6");
        chk(dm_mem[30] == 16'd255, "R5", "sum just under upper edge", dm_mem[30], 255);
        chk(dm_mem[31] == 16'd255, "R5", "sum at upper edge", dm_mem[31], 255);
        chk(dm_mem[32] == 16'd0, "R5", "sum at lower edge", dm_mem[32], 0);
        chk(dm_mem[33] == 16'd0, "R6", "sum below lower edge", dm_mem[33], 0);
        chk(dm_mem[34] == 16'd128, "R7", "cell index past array", dm_mem[34], 128);
        chk(dm_mem[36] == 16'd255, "R3", "sum unchanged by store", dm_mem[36], 255);
        chk(dm_mem[35] == 16'd128, "R4", "sum zero after clear", dm_mem[35], 128);

        // random two-layer networks
        for (int t = 0; t < 20; t++) begin
            wipe();
            k_in = int'($urandom_range(4, 1));
            h_n  = int'($urandom_range(4, 1));
            for (int i = 0; i < k_in; i++) begin
                rnd_word(v);
                setd(i, v);
                rnd_word(l0); rnd_word(l1); rnd_word(l2); rnd_word(l3);
                setw(i, l0, l1, l2, l3);
            end
            for (int n = 0; n < h_n; n++) begin
                rnd_word(l0); rnd_word(l1); rnd_word(l2); rnd_word(l3);
                setw(8 + n, l0, l1, l2, l3);
            end
            put(2'b10, 0, 0);
            for (int i = 0; i < k_in; i++) put(2'b00, i, i);
            for (int n = 0; n < h_n; n++) put(2'b01, n, 16 + n);
            put(2'b10, 0, 0);
            for (int n = 0; n < h_n; n++) put(2'b00, 16 + n, 8 + n);
            put(2'b01, 0, 40);
            put(2'b01, int'($urandom_range(3)), 41);
            put(2'b11, 0, 0);
            @(negedge clk);
            exec_check("R2 R3 R10");
        end

        // done holds, no access, then restart from address 0 (R9)
        v = 0;
        repeat (6) begin
            @(negedge clk);
            if (!done || code_ren || dm_ren || dm_wen || wt_ren) v++;
        end
        chk(v == 0, "R9", "quiet while done", v, 0);
        exec_check("R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule